// File: doc/BRIEF.md
# Marker Segment Tap

This block watches a byte-wide compressed image stream and copies chosen marker segments to a second byte-wide port. A downstream reader drains that port one byte per pull. A small marker detector follows the byte stream on its own. It tracks the 0xFF prefix, the marker code, the 16-bit length field and the entropy-coded scan data, and from these it decides which input bytes belong to a segment that should be copied.

A five-bit group selector picks the segment families to copy. It is captured once, on the first byte of each image stream, and is then held until the end-of-image marker has been taken. Copied bytes wait in a small output queue. When the queue is close to full, the block stops taking input, so the upstream source is stalled and no copied byte is ever dropped. Start-of-image and end-of-image bytes on the output are labelled through a two-bit indicator.

Top module: `hdr_tap`

## Requirements
- R1: Selector bit 0 copies huffman-table segments (code 0xC4). Bit 1 copies quantisation-table segments (0xDB). Bit 2 copies restart-interval segments (0xDD). Bit 3 copies comment (0xFE) and application (0xE0 to 0xEF) segments. Bit 4 copies frame headers (0xC0 to 0xCF other than 0xC4, 0xC8 and 0xCC), scan headers (0xDA) and line-count segments (0xDC). Any other length-carrying marker is never copied.
- R2: A copied segment appears on the output complete and in input order: 0xFF, the marker code, the high length byte, the low length byte, then length minus two payload bytes.
- R3: The selector is sampled on the first byte accepted after reset or after an end-of-image marker. Changes on the selector later in the same stream have no effect.
- R4: The start-of-image pair (0xFF 0xD8) and the end-of-image pair (0xFF 0xD9) are copied exactly when the sampled selector is non-zero. Acceptance of 0xD9 ends the stream.
- R5: While `outAvail` is high and `pull` is low, `outByte` and `imgMark` hold. A clock edge with `pull` high and `outAvail` high moves to the next queued byte.
- R6: `inReady` is low whenever the queue holds DEPTH-1 or more bytes, and high otherwise. Every byte due for copying reaches the output.
- R7: `imgMark` reads 2'b10 on both start-of-image bytes, 2'b01 on both end-of-image bytes, and 2'b00 on every other byte and whenever `outAvail` is low.
- R8: After a scan header, bytes are entropy data and are not copied. Within that data, 0xFF 0x00 and the restart codes 0xFF 0xD0 to 0xFF 0xD7 do not end the scan. A following marker such as 0xD9 or 0xDC is still recognised.
- R9: Payload bytes are counted by the length field, so 0xFF or 0xD9 bytes inside a payload are never taken as markers.
- R10: After reset, `outAvail` is low, `imgMark` is 2'b00 and `inReady` is high.
- R11: Repeated 0xFF fill bytes before a marker code are absorbed. A copied marker is output with a single 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| maskIn | input | 5 | Segment group selector, sampled at stream start |
| inByte | input | 8 | Compressed stream byte |
| inValid | input | 1 | inByte carries a byte this cycle |
| inReady | output | 1 | Block accepts a byte this cycle |
| outByte | output | 8 | Head of the copy queue |
| outAvail | output | 1 | outByte holds a copied byte |
| pull | input | 1 | Reader takes outByte at this edge |
| imgMark | output | 2 | 2'b10 on start-of-image bytes, 2'b01 on end-of-image bytes |

## Verification
A detector that drifts out of step shows up within a few bytes. It either copies payload or scan data that should be skipped, or it misses a selected segment, and the byte-for-byte queue model catches the first wrong or missing output byte. A wrong queue count shows up on `inReady` in the very cycle it happens, because the ready level is compared against the model size on every clock. Selector-hold faults are exposed because the bench drives the inverted selector on every byte except the first of each stream.

// File: rtl/hdr_tap_pkg.sv
package hdr_tap_pkg;

  localparam int GROUPS = 5;
  localparam int G_HUFF  = 0;
  localparam int G_QUANT = 1;
  localparam int G_RSTDF = 2;
  localparam int G_TEXT  = 3;
  localparam int G_FRAME = 4;

  localparam logic [1:0] TAG_NONE  = 2'b00;
  localparam logic [1:0] TAG_START = 2'b10;
  localparam logic [1:0] TAG_END   = 2'b01;

  localparam logic [7:0] BYTE_MARK  = 8'hFF;
  localparam logic [7:0] BYTE_STUFF = 8'h00;
  localparam logic [7:0] CODE_START = 8'hD8;
  localparam logic [7:0] CODE_END   = 8'hD9;
  localparam logic [7:0] CODE_SCAN  = 8'hDA;

  typedef enum logic [2:0] {
    ST_SEEK,    // marker mode, waiting for 0xFF
    ST_MARK,    // 0xFF seen in marker mode
    ST_LENH,    // next byte: length high
    ST_LENL,    // next byte: length low
    ST_BODY,    // payload bytes
    ST_SCAN,    // entropy-coded data
    ST_SCANFF   // 0xFF seen inside entropy data
  } tapState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       pushPair;   // queue 0xFF and the current code
    logic       pushOne;    // queue the current byte
    logic [1:0] tag;        // label for a pushed pair
    logic       sampleMask; // capture the group selector
    logic       loadHi;     // capture length high byte
    logic       loadLen;    // load payload counter
    logic       stepBody;   // one payload byte consumed
  } tapCtl_t;

  // Codes that stand alone, without a length field
  function automatic logic isStandalone(input logic [7:0] code);
    return (code == 8'h01) || (code[7:3] == 5'b11010);
  endfunction

  // One-hot group of a length-carrying marker code, zero when in no group
  function automatic logic [GROUPS-1:0] groupHot(input logic [7:0] code);
    logic [GROUPS-1:0] g;
    g = '0;
    if (code == 8'hC4)
      g[G_HUFF] = 1'b1;
    else if (code == 8'hDB)
      g[G_QUANT] = 1'b1;
    else if (code == 8'hDD)
      g[G_RSTDF] = 1'b1;
    else if (code == 8'hFE || code[7:4] == 4'hE)
      g[G_TEXT] = 1'b1;
    else if ((code[7:4] == 4'hC && code != 8'hC8 && code != 8'hCC) ||
             code == CODE_SCAN || code == 8'hDC)
      g[G_FRAME] = 1'b1;
    return g;
  endfunction

endpackage

// File: rtl/hdr_tap_fifo.sv
module hdr_tap_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrA,
  input  logic [WIDTH-1:0] dA,
  input  logic             wrB,
  input  logic [WIDTH-1:0] dB,
  input  logic             rdReq,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             almostFull
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr, wrNext;
  logic [CW-1:0]    cnt;
  logic             pop;
  logic [CW-1:0]    nPush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wrNext     = bump(wrPtr);
  assign pop        = rdReq && (cnt != '0);
  assign nPush      = CW'(wrA) + CW'(wrB);
  assign rdData     = mem[rdPtr];
  assign rdValid    = (cnt != '0);
  assign almostFull = (cnt >= CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wrA) mem[wrPtr]  <= dA;
    if (wrB) mem[wrNext] <= dB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (wrA && wrB)  wrPtr <= bump(wrNext);
      else if (wrA)    wrPtr <= wrNext;
      if (pop)         rdPtr <= bump(rdPtr);
      cnt <= cnt + nPush - CW'(pop);
    end
  end

  // R5: an unread head entry stays put
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReq) |=> (rdValid && $stable(rdData)));

  // R6: pair writes only with two free slots, single writes with one
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrB |-> (cnt <= CW'(DEPTH - 2)));

  p_single_room_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrA |-> (cnt <= CW'(DEPTH - 1)));

endmodule

// File: rtl/hdr_tap_dp.sv
module hdr_tap_dp
  import hdr_tap_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tapCtl_t           ctl,
  input  logic [7:0]        inByte,
  input  logic [GROUPS-1:0] maskIn,
  input  logic              pull,
  input  logic              inStream,
  output logic [GROUPS-1:0] maskQ,
  output logic              lenShort,
  output logic              lastBody,
  output logic              inReady,
  output logic [7:0]        outByte,
  output logic              outAvail,
  output logic [1:0]        imgMark
);

  localparam int ENTRY_W = 10;

  logic [7:0]         hiQ;
  logic [15:0]        remQ;
  logic [15:0]        lenFull;
  logic               wrA, wrB;
  logic [ENTRY_W-1:0] dA, dB, rdData;
  logic               rdValid, almostFull;

  assign lenFull  = {hiQ, inByte};
  assign lenShort = (lenFull <= 16'd2);
  assign lastBody = (remQ == 16'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      hiQ   <= '0;
      remQ  <= '0;
    end else begin
      if (ctl.sampleMask) maskQ <= maskIn;
      if (ctl.loadHi)     hiQ   <= inByte;
      if (ctl.loadLen)    remQ  <= lenFull - 16'd2;
      else if (ctl.stepBody) remQ <= remQ - 16'd1;
    end
  end

  assign wrA = ctl.pushPair || ctl.pushOne;
  assign wrB = ctl.pushPair;
  assign dA  = ctl.pushPair ? {ctl.tag, BYTE_MARK} : {TAG_NONE, inByte};
  assign dB  = {ctl.tag, inByte};

  hdr_tap_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) uFifo (
    .clk        (clk),
    .rstN       (rstN),
    .wrA        (wrA),
    .dA         (dA),
    .wrB        (wrB),
    .dB         (dB),
    .rdReq      (pull),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .almostFull (almostFull)
  );

  assign inReady  = !almostFull;
  assign outAvail = rdValid;
  assign outByte  = rdData[7:0];
  assign imgMark  = rdValid ? rdData[9:8] : TAG_NONE;

  // R3: selector held for the rest of a stream
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inStream && !ctl.sampleMask) |=> $stable(maskQ));

  // R2/R9: payload stepping never runs past the length field
  p_body_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepBody |-> (remQ != 16'd0));

endmodule

// File: rtl/hdr_tap_ctl.sv
module hdr_tap_ctl
  import hdr_tap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  input  logic              inReady,
  input  logic [GROUPS-1:0] maskQ,
  input  logic              lenShort,
  input  logic              lastBody,
  output tapCtl_t           ctl,
  output logic              inStream
);

  tapState_e state, stateNext, afterSeg, resume;
  logic      fwdQ, fwdNext, sosQ, sosNext;
  logic      acc, endSeen;

  assign acc = inValid && inReady;

  always_comb begin
    stateNext      = state;
    fwdNext        = fwdQ;
    sosNext        = sosQ;
    endSeen        = 1'b0;
    ctl            = '0;
    ctl.sampleMask = acc && !inStream;
    afterSeg       = sosQ ? ST_SCAN : ST_SEEK;
    resume         = (state == ST_SCANFF) ? ST_SCAN : ST_SEEK;
    if (acc) begin
      case (state)
        ST_SEEK:  if (inByte == BYTE_MARK) stateNext = ST_MARK;
        ST_SCAN:  if (inByte == BYTE_MARK) stateNext = ST_SCANFF;
        ST_MARK, ST_SCANFF: begin
          if (inByte == BYTE_MARK) begin
            stateNext = state;                       // fill byte
          end else if (inByte == BYTE_STUFF || isStandalone(inByte)) begin
            stateNext = resume;
          end else if (inByte == CODE_START || inByte == CODE_END) begin
            ctl.pushPair = |maskQ;
            ctl.tag      = (inByte == CODE_START) ? TAG_START : TAG_END;
            endSeen      = (inByte == CODE_END);
            stateNext    = ST_SEEK;
          end else begin
            fwdNext      = |(groupHot(inByte) & maskQ);
            ctl.pushPair = fwdNext;
            sosNext      = (inByte == CODE_SCAN);
            stateNext    = ST_LENH;
          end
        end
        ST_LENH: begin
          ctl.loadHi  = 1'b1;
          ctl.pushOne = fwdQ;
          stateNext   = ST_LENL;
        end
        ST_LENL: begin
          ctl.loadLen = 1'b1;
          ctl.pushOne = fwdQ;
          stateNext   = lenShort ? afterSeg : ST_BODY;
        end
        ST_BODY: begin
          ctl.stepBody = 1'b1;
          ctl.pushOne  = fwdQ;
          if (lastBody) stateNext = afterSeg;
        end
        default: stateNext = ST_SEEK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SEEK;
      fwdQ     <= 1'b0;
      sosQ     <= 1'b0;
      inStream <= 1'b0;
    end else begin
      state <= stateNext;
      fwdQ  <= fwdNext;
      sosQ  <= sosNext;
      if (acc) inStream <= !endSeen;
    end
  end

  // R4: an accepted end code closes the stream and returns to marker mode
  p_end_closes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (acc && (state == ST_MARK || state == ST_SCANFF) && inByte == CODE_END)
      |=> (state == ST_SEEK && !inStream));

  // R8: ordinary entropy bytes keep the scan going
  p_scan_stay_r8: assert property (@(posedge clk) disable iff (!rstN)
    (acc && state == ST_SCAN && inByte != BYTE_MARK) |=> (state == ST_SCAN));

endmodule

// File: rtl/hdr_tap.sv
module hdr_tap
  import hdr_tap_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] maskIn,
  input  logic [7:0] inByte,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] outByte,
  output logic       outAvail,
  input  logic       pull,
  output logic [1:0] imgMark
);

  tapCtl_t           ctl;
  logic              inStream;
  logic [GROUPS-1:0] maskQ;
  logic              lenShort, lastBody;

  hdr_tap_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .inValid  (inValid),
    .inReady  (inReady),
    .maskQ    (maskQ),
    .lenShort (lenShort),
    .lastBody (lastBody),
    .ctl      (ctl),
    .inStream (inStream)
  );

  hdr_tap_dp #(.DEPTH(DEPTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inByte   (inByte),
    .maskIn   (maskIn),
    .pull     (pull),
    .inStream (inStream),
    .maskQ    (maskQ),
    .lenShort (lenShort),
    .lastBody (lastBody),
    .inReady  (inReady),
    .outByte  (outByte),
    .outAvail (outAvail),
    .imgMark  (imgMark)
  );

endmodule

// File: tb/hdr_tap_test.sv
module hdr_tap_test;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] maskIn;
  logic [7:0] inByte;
  logic       inValid;
  logic       inReady;
  logic [7:0] outByte;
  logic       outAvail;
  logic       pull;
  logic [1:0] imgMark;

  always #4 clk = ~clk;

  hdr_tap #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .maskIn(maskIn), .inByte(inByte),
    .inValid(inValid), .inReady(inReady), .outByte(outByte),
    .outAvail(outAvail), .pull(pull), .imgMark(imgMark)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] stim[$];
  logic [4:0] stimMask[$];
  int         expN[$];
  logic [9:0] expA[$];
  logic [9:0] expB[$];
  logic [9:0] model[$];
  logic [4:0] curMask;
  bit         firstByte;
  string      curReq;
  bit         lastStall;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearStim();
    stim.delete(); stimMask.delete(); expN.delete(); expA.delete(); expB.delete();
  endtask

  task automatic addIn(input logic [7:0] b, input int n, input logic [9:0] a, input logic [9:0] bb);
    stim.push_back(b);
    stimMask.push_back(firstByte ? curMask : ~curMask);  // later bytes see a changed selector (R3)
    firstByte = 1'b0;
    expN.push_back(n); expA.push_back(a); expB.push_back(bb);
  endtask

  task automatic newStream(input logic [4:0] m);
    curMask = m; firstByte = 1'b1;
  endtask

  task automatic addFill();
    addIn(8'hFF, 0, 10'h0, 10'h0);
  endtask

  // start/end-of-image pair (R4, R7)
  task automatic addImgMarker(input logic [7:0] code, input logic [1:0] tag);
    int n = (curMask != 5'h0) ? 2 : 0;
    addIn(8'hFF, 0, 10'h0, 10'h0);
    addIn(code, n, {tag, 8'hFF}, {tag, code});
  endtask

  // whole segment (R1, R2, R9)
  task automatic addSeg(input logic [7:0] code, input int grp, input int n, input int seed);
    bit f = (grp >= 0) && curMask[grp];
    int len = n + 2;
    logic [7:0] v;
    addIn(8'hFF, 0, 10'h0, 10'h0);
    addIn(code, f ? 2 : 0, {2'b00, 8'hFF}, {2'b00, code});
    v = 8'((len >> 8) & 255);
    addIn(v, f ? 1 : 0, {2'b00, v}, 10'h0);
    v = 8'(len & 255);
    addIn(v, f ? 1 : 0, {2'b00, v}, 10'h0);
    for (int j = 0; j < n; j++) begin
      if (j == 1) v = 8'hFF;
      else if (j == 2) v = 8'hD9;
      else v = 8'((seed * 31 + j * 37) & 255);
      addIn(v, f ? 1 : 0, {2'b00, v}, 10'h0);
    end
  endtask

  // entropy data with stuffing and restart codes (R8)
  task automatic addScan(input int n, input int seed);
    logic [7:0] v;
    for (int j = 0; j < n; j++) begin
      v = 8'((seed * 13 + j * 29) & 255);
      if (v == 8'hFF) v = 8'hFE;
      addIn(v, 0, 10'h0, 10'h0);
      if (j % 5 == 2) begin addIn(8'hFF, 0, 10'h0, 10'h0); addIn(8'h00, 0, 10'h0, 10'h0); end
      if (j == n / 2) begin addIn(8'hFF, 0, 10'h0, 10'h0); addIn(8'(8'hD0 + (j & 7)), 0, 10'h0, 10'h0); end
    end
  endtask

  task automatic buildFull(input logic [4:0] m);
    newStream(m);
    addImgMarker(8'hD8, 2'b10);
    addSeg(8'hE1, 3, 5, 1);
    addSeg(8'hFE, 3, 3, 2);
    addFill();                       // R11: extra fill before the marker
    addSeg(8'hDB, 1, 6, 3);
    addSeg(8'hC0, 4, 8, 4);
    addSeg(8'hC4, 0, 7, 5);
    addSeg(8'hDD, 2, 2, 6);
    addSeg(8'hF5, -1, 4, 7);         // R1: length marker in no group
    addSeg(8'hDA, 4, 4, 8);
    addScan(10, 9);
    addSeg(8'hDC, 4, 2, 10);
    addFill();
    addImgMarker(8'hD9, 2'b01);
  endtask

  // Runs the queued stimulus against the queue model, compared every clock
  task automatic runPhase(input int pp, input int vp);
    int idx = 0;
    int cyc = 0;
    int popped = 0;
    int expTotal = 0;
    bit rm;
    lastStall = 1'b0;
    foreach (expN[i]) expTotal += expN[i];
    forever begin
      @(negedge clk);
      check(curReq, "outAvail", int'(outAvail), int'(model.size() != 0));
      check("R6", "inReady", int'(inReady), int'(model.size() <= DEPTH - 2));
      if (!inReady) lastStall = 1'b1;
      if (model.size() != 0) begin
        check(curReq, "outByte", int'(outByte), int'(model[0][7:0]));
        check("R7", "imgMark", int'(imgMark), int'(model[0][9:8]));
      end else begin
        check("R7", "imgMark idle", int'(imgMark), 0);
      end
      if (idx >= stim.size() && model.size() == 0) break;
      if (cyc > 20000) begin
        check(curReq, "watchdog", 1, 0);
        break;
      end
      pull    = ((cyc % pp) == 0);
      inValid = (idx < stim.size()) && ((cyc % vp) == 0);
      if (idx < stim.size()) begin
        inByte = stim[idx];
        maskIn = stimMask[idx];
      end
      rm = (model.size() <= DEPTH - 2);
      if (pull && model.size() != 0) begin
        void'(model.pop_front());
        popped++;
      end
      if (inValid && rm) begin
        if (expN[idx] >= 1) model.push_back(expA[idx]);
        if (expN[idx] >= 2) model.push_back(expB[idx]);
        idx++;
      end
      cyc++;
    end
    inValid = 1'b0;
    pull    = 1'b0;
    check(curReq, "bytes copied", popped, expTotal);
  endtask

  initial begin
    #(8 * 190000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; maskIn = '0; inByte = '0; inValid = 1'b0; pull = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "outAvail", int'(outAvail), 0);
    check("R10", "inReady", int'(inReady), 1);
    check("R10", "imgMark", int'(imgMark), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "outAvail after release", int'(outAvail), 0);

    curReq = "R2 R7 R9 R11";
    clearStim(); buildFull(5'h1F);
    runPhase(1, 1);

    curReq = "R1 R3";
    clearStim();
    buildFull(5'h01); buildFull(5'h02); buildFull(5'h04); buildFull(5'h08); buildFull(5'h10);
    runPhase(2, 3);

    curReq = "R4";
    clearStim(); buildFull(5'h00); buildFull(5'h02);
    runPhase(1, 1);

    curReq = "R8";
    clearStim(); newStream(5'h1F);
    addImgMarker(8'hD8, 2'b10);
    addSeg(8'hDA, 4, 6, 12);
    addScan(30, 3);
    addImgMarker(8'hD9, 2'b01);
    runPhase(1, 2);

    curReq = "R5 R6";
    clearStim(); newStream(5'h1F);
    addImgMarker(8'hD8, 2'b10);
    addSeg(8'hE3, 3, 40, 11);
    addImgMarker(8'hD9, 2'b01);
    runPhase(6, 1);
    check("R6", "stall seen", int'(lastStall), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule